// File: doc/BRIEF.md
# Signed Halfword Multiply Unit

This execution-stage datapath block multiplies signed operands in two ways. In halfword mode it picks one 16-bit half from each 32-bit source, treats both as signed, and returns their full 32-bit signed product. In word mode it multiplies the whole first source, taken as a signed 32-bit value, by one signed half of the second source. It then keeps only the top 32 bits of the 48-bit product.

Operations arrive through a valid/ready handshake. The ready output is always high, so a new operation can enter on every cycle. Each result leaves a two-stage register pipeline together with its destination index and a write-enable for writeback. If any of the three register indices names the stack pointer (13) or the program counter (15), the operation is flagged as illegal and its write is held back. No status flags are produced in either mode.

Top module: `smul_halfword_unit`

## Requirements
- R1: In halfword mode (`mode`=0), `sel_x`=0 takes `op_a[15:0]` and `sel_x`=1 takes `op_a[31:16]` as the first factor.
- R2: In both modes, `sel_y`=0 takes `op_b[15:0]` and `sel_y`=1 takes `op_b[31:16]` as the second factor.
- R3: In halfword mode, both chosen halves are signed 16-bit values and `out_result` is their complete signed 32-bit product. The case 0x8000 times 0x8000 gives 0x40000000 and raises no overflow indication.
- R4: In word mode (`mode`=1), `op_a` is a signed 32-bit value multiplied by the chosen signed half. `out_result` is bits [47:16] of the 48-bit signed product.
- R5: If `rd_idx`, `rn_idx` or `rm_idx` equals 13 or 15, the result appears with `out_illegal`=1 and `out_wr_en`=0. Otherwise `out_illegal`=0 and `out_wr_en`=1 while `out_valid` is high.
- R6: An operation accepted at a rising edge shows on the outputs after the next rising edge. `out_valid` is high for one cycle per operation, and operations may enter on consecutive cycles.
- R7: Synchronous active-high `rst` clears the pipeline valid bits and the illegal flag, including any operation already in flight.
- R8: `out_rd_idx` carries the `rd_idx` of the operation whose result is on `out_result`.
- R9: `in_ready` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken (always 1) |
| mode | input | 1 | 0 = halfword by halfword, 1 = word by halfword |
| sel_x | input | 1 | First-source half select (halfword mode) |
| sel_y | input | 1 | Second-source half select |
| op_a | input | 32 | First source value |
| op_b | input | 32 | Second source value |
| rd_idx | input | 4 | Destination register index |
| rn_idx | input | 4 | First source register index |
| rm_idx | input | 4 | Second source register index |
| out_valid | output | 1 | Result present, one-cycle pulse |
| out_result | output | 32 | Product or truncated product |
| out_rd_idx | output | 4 | Destination index for the result |
| out_wr_en | output | 1 | Writeback allowed |
| out_illegal | output | 1 | Forbidden register index used |

## Verification
The halfword sweep uses a set of half values that includes zero, ±1, the largest positive value and the most negative value. It runs every pair of these under all four select combinations. The half that is not selected always holds a different value, so taking the wrong half changes the product. The word sweep pairs sign-boundary words with the same halves, which separates a truncated high part from a low part or from an unsigned product. Idle gaps are mixed with back-to-back issue to check latency and single-cycle valid pulses. A reset in the middle of an operation, and forbidden indices placed in each of the three index positions, check flag clearing and write suppression.

// File: rtl/smul_pkg.sv
package smul_pkg;
    localparam int DATA_W  = 32;
    localparam int HALF_W  = DATA_W / 2;
    localparam int PROD_W  = DATA_W + HALF_W;
    localparam int IDX_W   = 4;
    localparam int NUM_IDX = 3;

    localparam logic [IDX_W-1:0] SP_IDX = IDX_W'(13);
    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(15);

    typedef enum logic {
        MODE_HH = 1'b0,
        MODE_WH = 1'b1
    } mul_mode_e;

    typedef struct packed {
        logic             valid;
        mul_mode_e        mode;
        logic [DATA_W-1:0] word;
        logic [HALF_W-1:0] half;
        logic [IDX_W-1:0]  rd;
        logic             illegal;
    } stage1_t;

    typedef struct packed {
        logic             valid;
        logic [DATA_W-1:0] result;
        logic [IDX_W-1:0]  rd;
        logic             illegal;
    } stage2_t;

    function automatic logic idx_forbidden(input logic [IDX_W-1:0] idx);
        return (idx == SP_IDX) || (idx == PC_IDX);
    endfunction
endpackage

// File: rtl/smul_operand_sel.sv
module smul_operand_sel
    import smul_pkg::*;
(
    input  mul_mode_e         mode,
    input  logic              sel_x,
    input  logic              sel_y,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] word_opnd,
    output logic [HALF_W-1:0] half_opnd
);
    logic [HALF_W-1:0] a_half;

    always_comb begin
        a_half    = sel_x ? op_a[DATA_W-1:HALF_W] : op_a[HALF_W-1:0];
        half_opnd = sel_y ? op_b[DATA_W-1:HALF_W] : op_b[HALF_W-1:0];
        if (mode == MODE_WH) begin
            word_opnd = op_a;
        end else begin
            word_opnd = {{HALF_W{a_half[HALF_W-1]}}, a_half};
        end
    end
endmodule

// File: rtl/smul_index_check.sv
module smul_index_check
    import smul_pkg::*;
(
    input  logic [NUM_IDX-1:0][IDX_W-1:0] idx_list,
    output logic                          any_forbidden
);
    logic [NUM_IDX-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_IDX; g++) begin : g_src
            assign hit[g] = idx_forbidden(idx_list[g]);
        end
    endgenerate

    assign any_forbidden = |hit;
endmodule

// File: rtl/smul_product.sv
module smul_product
    import smul_pkg::*;
(
    input  mul_mode_e         mode,
    input  logic [DATA_W-1:0] word_opnd,
    input  logic [HALF_W-1:0] half_opnd,
    output logic [DATA_W-1:0] result
);
    logic signed [PROD_W-1:0] word_ext;
    logic signed [PROD_W-1:0] half_ext;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        word_ext = $signed({{HALF_W{word_opnd[DATA_W-1]}}, word_opnd});
        half_ext = $signed({{DATA_W{half_opnd[HALF_W-1]}}, half_opnd});
        prod     = word_ext * half_ext;
        if (mode == MODE_WH) begin
            result = prod[PROD_W-1:HALF_W];
        end else begin
            result = prod[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/smul_halfword_unit.sv
module smul_halfword_unit
    import smul_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              mode,
    input  logic              sel_x,
    input  logic              sel_y,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rn_idx,
    input  logic [IDX_W-1:0]  rm_idx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [IDX_W-1:0]  out_rd_idx,
    output logic              out_wr_en,
    output logic              out_illegal
);
    mul_mode_e         mode_e;
    logic [DATA_W-1:0] word_opnd;
    logic [HALF_W-1:0] half_opnd;
    logic              forbidden;
    logic [DATA_W-1:0] prod_result;
    stage1_t           s1_q;
    stage2_t           s2_q;

    assign mode_e   = mul_mode_e'(mode);
    assign in_ready = 1'b1;

    smul_operand_sel u_sel (
        .mode      (mode_e),
        .sel_x     (sel_x),
        .sel_y     (sel_y),
        .op_a      (op_a),
        .op_b      (op_b),
        .word_opnd (word_opnd),
        .half_opnd (half_opnd)
    );

    smul_index_check u_idx (
        .idx_list      ({rd_idx, rn_idx, rm_idx}),
        .any_forbidden (forbidden)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid   <= in_valid;
            s1_q.mode    <= mode_e;
            s1_q.word    <= word_opnd;
            s1_q.half    <= half_opnd;
            s1_q.rd      <= rd_idx;
            s1_q.illegal <= in_valid & forbidden;
        end
    end

    smul_product u_prod (
        .mode      (s1_q.mode),
        .word_opnd (s1_q.word),
        .half_opnd (s1_q.half),
        .result    (prod_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q.valid   <= s1_q.valid;
            s2_q.result  <= prod_result;
            s2_q.rd      <= s1_q.rd;
            s2_q.illegal <= s1_q.illegal;
        end
    end

    assign out_valid   = s2_q.valid;
    assign out_result  = s2_q.result;
    assign out_rd_idx  = s2_q.rd;
    assign out_illegal = s2_q.illegal;
    assign out_wr_en   = s2_q.valid & ~s2_q.illegal;

    // Cycles since reset, saturating, so $past never reaches before reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd2) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    assert_wr_needs_legal_R5: assert property (@(posedge clk) disable iff (rst)
        out_wr_en |-> (out_valid && !out_illegal));

    assert_illegal_flag_R5: assert property (@(posedge clk) disable iff (rst)
        ((warm_q == 2'd2) && $past(in_valid && (idx_forbidden(rd_idx) ||
          idx_forbidden(rn_idx) || idx_forbidden(rm_idx)), 2)) |-> out_illegal);

    assert_rd_carried_R8: assert property (@(posedge clk) disable iff (rst)
        ((warm_q == 2'd2) && out_valid) |-> (out_rd_idx == $past(rd_idx, 2)));

    assert_illegal_only_valid_R7: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> out_valid);
endmodule

// File: tb/tb_smul_halfword_unit.sv
module tb_smul_halfword_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        mode = 1'b0;
    logic        sel_x = 1'b0;
    logic        sel_y = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  rd_idx = '0;
    logic [3:0]  rn_idx = '0;
    logic [3:0]  rm_idx = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [3:0]  out_rd_idx;
    logic        out_wr_en;
    logic        out_illegal;

    smul_halfword_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .mode(mode), .sel_x(sel_x), .sel_y(sel_y), .op_a(op_a), .op_b(op_b),
        .rd_idx(rd_idx), .rn_idx(rn_idx), .rm_idx(rm_idx),
        .out_valid(out_valid), .out_result(out_result), .out_rd_idx(out_rd_idx),
        .out_wr_en(out_wr_en), .out_illegal(out_illegal)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit mon_en   = 1'b0;
    bit done     = 1'b0;

    logic [31:0] exp_res [0:1023];
    logic        exp_wr  [0:1023];
    logic        exp_ill [0:1023];
    logic [3:0]  exp_rd  [0:1023];
    int          exp_cyc [0:1023];
    string       exp_tag [0:1023];
    int wp = 0;
    int rp = 0;

    logic [15:0] hv [0:7];
    logic [31:0] wv [0:7];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [31:0] model(input logic m, input logic x, input logic y,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [15:0]        ha;
        logic [15:0]        hb;
        logic signed [63:0] pa;
        logic signed [63:0] pb;
        logic signed [63:0] p;
        ha = x ? a[31:16] : a[15:0];
        hb = y ? b[31:16] : b[15:0];
        pb = $signed({{48{hb[15]}}, hb});
        if (!m) pa = $signed({{48{ha[15]}}, ha});
        else    pa = $signed({{32{a[31]}}, a});
        p = pa * pb;
        return m ? p[47:16] : p[31:0];
    endfunction

    task automatic send(input logic m, input logic x, input logic y,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] rd, input logic [3:0] rn, input logic [3:0] rm,
                        input string tag, input bit push);
        bit bad;
        @(negedge clk);
        chk(in_ready === 1'b1, "R9 in_ready", {31'd0, in_ready}, 32'd1);
        in_valid = 1'b1; mode = m; sel_x = x; sel_y = y;
        op_a = a; op_b = b; rd_idx = rd; rn_idx = rn; rm_idx = rm;
        if (push) begin
            bad = (rd == 4'd13) || (rd == 4'd15) || (rn == 4'd13) || (rn == 4'd15) ||
                  (rm == 4'd13) || (rm == 4'd15);
            exp_res[wp] = model(m, x, y, a, b);
            exp_wr[wp]  = !bad;
            exp_ill[wp] = bad;
            exp_rd[wp]  = rd;
            exp_cyc[wp] = cyc + 2;
            exp_tag[wp] = tag;
            wp++;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (mon_en && !done) begin
            if (out_valid) begin
                if (rp >= wp) begin
                    chk(1'b0, "R6 unexpected out_valid", 32'd1, 32'd0);
                end else begin
                    chk(exp_cyc[rp] == cyc, "R6 latency", 32'(cyc), 32'(exp_cyc[rp]));
                    chk(out_wr_en === exp_wr[rp], "R5 wr_en", {31'd0, out_wr_en}, {31'd0, exp_wr[rp]});
                    chk(out_illegal === exp_ill[rp], "R5 illegal", {31'd0, out_illegal}, {31'd0, exp_ill[rp]});
                    chk(out_rd_idx === exp_rd[rp], "R8 rd index", {28'd0, out_rd_idx}, {28'd0, exp_rd[rp]});
                    if (exp_wr[rp])
                        chk(out_result === exp_res[rp], exp_tag[rp], out_result, exp_res[rp]);
                    rp++;
                end
            end else if (rp < wp && exp_cyc[rp] == cyc) begin
                chk(1'b0, "R6 missing out_valid", 32'd0, 32'd1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        hv[0] = 16'h0000; hv[1] = 16'h0001; hv[2] = 16'hFFFF; hv[3] = 16'h7FFF;
        hv[4] = 16'h8000; hv[5] = 16'h1234; hv[6] = 16'hEDCB; hv[7] = 16'h0002;
        wv[0] = 32'h0000_0000; wv[1] = 32'h0000_0001; wv[2] = 32'hFFFF_FFFF;
        wv[3] = 32'h7FFF_FFFF; wv[4] = 32'h8000_0000; wv[5] = 32'h1234_5678;
        wv[6] = 32'hCAFE_F00D; wv[7] = 32'h0001_0000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R7: outputs cleared while reset is held
        chk(out_valid === 1'b0, "R7 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk(out_illegal === 1'b0, "R7 reset out_illegal", {31'd0, out_illegal}, 32'd0);
        chk(out_wr_en === 1'b0, "R7 reset out_wr_en", {31'd0, out_wr_en}, 32'd0);
        rst = 1'b0;

        // R7: reset during an in-flight illegal operation discards it
        send(1'b0, 1'b0, 1'b0, 32'h0003_0003, 32'h0004_0004, 4'd13, 4'd1, 4'd2, "R7", 1'b0);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid === 1'b0, "R7 flush out_valid", {31'd0, out_valid}, 32'd0);
        chk(out_illegal === 1'b0, "R7 flush out_illegal", {31'd0, out_illegal}, 32'd0);
        @(negedge clk);
        chk(out_valid === 1'b0, "R7 flush later out_valid", {31'd0, out_valid}, 32'd0);
        chk(out_illegal === 1'b0, "R7 flush later out_illegal", {31'd0, out_illegal}, 32'd0);
        mon_en = 1'b1;

        // R3: most negative times most negative
        send(1'b0, 1'b1, 1'b0, 32'h8000_1111, 32'h2222_8000, 4'd3, 4'd4, 4'd5, "R3 0x8000 squared", 1'b1);
        idle();
        idle();

        // R1 R2 R3: halfword sweep, all selects, with idle gaps
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int s = 0; s < 4; s++) begin
                    logic [15:0] ja;
                    logic [15:0] jb;
                    logic [31:0] a;
                    logic [31:0] b;
                    ja = hv[(i + 3) % 8] ^ 16'h5A5A;
                    jb = hv[(j + 5) % 8] ^ 16'hA5A5;
                    a = s[1] ? {hv[i], ja} : {ja, hv[i]};
                    b = s[0] ? {hv[j], jb} : {jb, hv[j]};
                    send(1'b0, s[1], s[0], a, b, 4'((i + j + s) % 13), 4'(i % 13), 4'(j % 13),
                         "R1 R2 R3 halfword product", 1'b1);
                    if (((i * 32 + j * 4 + s) % 7) == 6) idle();
                end
            end
        end

        // R4 R2: word by halfword sweep
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int y = 0; y < 2; y++) begin
                    logic [15:0] jb;
                    logic [31:0] b;
                    jb = hv[(j + 2) % 8] ^ 16'h3C3C;
                    b = (y == 1) ? {hv[j], jb} : {jb, hv[j]};
                    send(1'b1, 1'b0, y[0], wv[i], b, 4'(14 - (i % 3)), 4'(j % 13), 4'(i % 13),
                         "R4 R2 word product", 1'b1);
                    if (((i + j + y) % 5) == 4) idle();
                end
            end
        end

        // R5: forbidden indices in each position
        send(1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 4'd13, 4'd1, 4'd2, "R5", 1'b1);
        send(1'b0, 1'b0, 1'b0, 32'h5, 32'h6, 4'd15, 4'd1, 4'd2, "R5", 1'b1);
        send(1'b1, 1'b0, 1'b1, 32'h5, 32'h6, 4'd3, 4'd13, 4'd2, "R5", 1'b1);
        send(1'b1, 1'b0, 1'b1, 32'h5, 32'h6, 4'd3, 4'd15, 4'd2, "R5", 1'b1);
        send(1'b0, 1'b1, 1'b1, 32'h5, 32'h6, 4'd3, 4'd1, 4'd13, "R5", 1'b1);
        send(1'b0, 1'b1, 1'b1, 32'h5, 32'h6, 4'd3, 4'd1, 4'd15, "R5", 1'b1);
        send(1'b0, 1'b0, 1'b0, 32'h7, 32'h9, 4'd14, 4'd12, 4'd0, "R5 legal neighbours", 1'b1);
        idle();
        repeat (4) idle();

        // R6: every issued operation produced exactly one result
        chk(rp == wp, "R6 result count", 32'(rp), 32'(wp));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule